// File: doc/BRIEF.md
# I2C EEPROM Target

This block is a synthesizable I2C target that behaves as a byte-addressed EEPROM. Its storage is an inferred RAM of up to 4096 bytes. A fast system clock samples the bus, and the block drives SDA only through an open-drain enable, where a high `sda_oe` pulls the line low. After reset the block fills every location with 0xFF. While that fill runs it ignores the bus.

The block matches a received address byte against an 8-bit base value. Any bit set in a don't-care mask is excluded from the comparison, and bit 0 of the base and mask is the direction bit. The block can take its byte offset in two ways. In the linear mode it receives one offset byte, or two (high byte first) when the capacity exceeds 256 bytes. In the paged mode it takes the high offset bits from the address byte and then receives a single low offset byte. A single internal pointer serves both reads and writes, and it advances after every data byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the block fills all `MEM_BYTES` locations with 0xFF over `MEM_BYTES` clock cycles, and it keeps SDA released until the fill completes.
- R2: An address byte `b` is acknowledged only when `((b ^ DEV_BASE) & ~DEV_MASK) == 0`. Otherwise the block sends no ACK and stays silent until the next START.
- R3: Address bit 0 is the direction flag (1 = read). With base 0xC1 and mask 0x00 the block acknowledges a read at 0xC1 and refuses a write at 0xC0.
- R4: In linear mode with `MEM_BYTES` above 256, two offset bytes follow the address, high byte first. With `MEM_BYTES` of 256 or less, only one follows.
- R5: In paged mode the address bits above bit 0 supply the offset bits above bit 7, masked to the capacity, and exactly one low offset byte follows.
- R6: The block pulls SDA low for the whole ninth clock after a matching address, after each offset byte and after each written data byte.
- R7: The pointer advances by one after every data byte read or written, and it wraps from `MEM_BYTES-1` to 0.
- R8: Read data leaves MSB first, and SDA changes only while SCL is low. After a controller NACK the block releases SDA until the next START.
- R9: A write transaction that ends after its offset bytes only loads the pointer, and a read that follows starts at that location.
- R10: A STOP (SDA rising with SCL high) returns the block to idle, so that bytes clocked before the next START are not acknowledged. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls SDA low |

## Verification
The bench puts three instances on one shared bus. The first has 512 bytes in linear mode with base 0xA0 and mask 0x01, so it receives two offset bytes, wraps at 0x1FF and accepts both directions. The second has 512 bytes in paged mode with base 0xB0 and mask 0x03, so address bit 1 selects the upper 256-byte half and two of its addresses reach separate data. The third has 64 bytes with base 0xC1 and mask 0x00, which makes it read-only with a one-byte offset, and it exposes the 0xFF fill through current-address reads.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_IGN
  } ee_state_t;

  typedef enum logic [1:0] {
    B_ADDR, B_OFSH, B_OFSL, B_DATA
  } ee_role_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          ready
);
  logic [7:0]    ram [DEPTH];
  logic [AW-1:0] fill_addr;
  logic          filling;

  // Erase sequencer: one location per cycle after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_addr <= '0;
      filling   <= 1'b1;
    end else if (filling) begin
      fill_addr <= fill_addr + 1'b1;
      if (fill_addr == AW'(DEPTH-1)) filling <= 1'b0;
    end
  end

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (filling)  ram[fill_addr] <= 8'hFF;
    else if (we)  ram[waddr]     <= wdata;
    rdata <= ram[raddr];
  end

  assign ready = ~filling;
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int         MEM_BYTES    = 256,
  parameter logic [7:0] DEV_BASE     = 8'hA0,
  parameter logic [7:0] DEV_MASK     = 8'h01,
  parameter bit         HI_FROM_ADDR = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int          AW      = (MEM_BYTES < 2) ? 1 : $clog2(MEM_BYTES);
  localparam bit          TWO_OFS = !HI_FROM_ADDR && (AW > 8);
  localparam logic [15:0] PMASK   = 16'(MEM_BYTES - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic mem_ready;
  logic [7:0] rdata;

  ee_state_t     state;
  ee_role_t      role, next_role;
  logic [7:0]    sreg, txsh, wdata;
  logic [3:0]    bitcnt;
  logic          rw, mnack, we;
  logic [15:0]   ptr, ptr_inc, ptr_paged;
  logic [AW-1:0] waddr;
  logic          match;

  i2c_ee_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr[AW-1:0]), .rdata(rdata), .ready(mem_ready)
  );

  always_comb begin
    match     = ((sreg ^ DEV_BASE) & ~DEV_MASK) == 8'h00;
    ptr_inc   = (ptr + 16'd1) & PMASK;
    ptr_paged = ((16'(sreg[7:1]) << 8) | {8'h00, ptr[7:0]}) & PMASK;
    case (role)
      B_ADDR:  next_role = TWO_OFS ? B_OFSH : B_OFSL;
      B_OFSH:  next_role = B_OFSL;
      default: next_role = B_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  role  <= B_ADDR;
      sreg  <= '0;      txsh  <= '0;     wdata <= '0;
      bitcnt <= '0;     rw    <= 1'b0;   mnack <= 1'b0;
      ptr   <= '0;      waddr <= '0;     we    <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (!mem_ready) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= S_RX;
        role   <= B_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              sreg   <= {sreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              state  <= S_RXACK;
              sda_oe <= 1'b1;
              case (role)
                B_ADDR: begin
                  if (match) begin
                    rw <= sreg[0];
                    if (HI_FROM_ADDR) ptr <= ptr_paged;
                  end else begin
                    state  <= S_IGN;
                    sda_oe <= 1'b0;
                  end
                end
                B_OFSH: ptr <= {sreg, ptr[7:0]} & PMASK;
                B_OFSL: ptr <= {ptr[15:8], sreg} & PMASK;
                default: begin
                  we    <= 1'b1;
                  wdata <= sreg;
                  waddr <= ptr[AW-1:0];
                  ptr   <= ptr_inc;
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (role == B_ADDR && rw) begin
                state  <= S_TX;
                txsh   <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                state  <= S_RX;
                role   <= next_role;
                sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                state  <= S_TXACK;
                sda_oe <= 1'b0;
                ptr    <= ptr_inc;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (!mnack) begin
                state  <= S_TX;
                txsh   <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                state <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
  import i2c_ee_pkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        mem_ready,
  input ee_state_t   state,
  input logic [15:0] ptr
);
  localparam logic [15:0] PM = 16'(MEM_BYTES - 1);

  // R1: bus stays released while the erase fill runs
  a_r1_quiet_fill: assert property (@(posedge clk) disable iff (rst)
    !mem_ready |-> !sda_oe);

  // R2: a refused address leaves the line alone
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == S_IGN) |-> !sda_oe);

  // R6: acknowledge held for the whole ninth clock
  a_r6_ack_held: assert property (@(posedge clk) disable iff (rst)
    (state == S_RXACK) |-> sda_oe);

  // R7: pointer steps by one (with wrap) at the end of each read byte
  a_r7_rd_step: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_TX && state == S_TXACK) |->
      ptr == (($past(ptr) + 16'd1) & PM));

  // R8: the drive changes only while SCL is low
  a_r8_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_eeprom_target i2c_ee_checker #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .mem_ready(mem_ready), .state(state), .ptr(ptr)
);

// File: tb/test_i2c_eeprom_target.sv
`timescale 1ns/1ps
module test_i2c_eeprom_target;
  localparam int H  = 10;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic oe_a, oe_b, oe_c;
  logic sda_bus;

  always #4 clk = ~clk;

  assign sda_bus = ~(m_low | oe_a | oe_b | oe_c);

  i2c_eeprom_target #(.MEM_BYTES(512), .DEV_BASE(8'hA0), .DEV_MASK(8'h01), .HI_FROM_ADDR(1'b0))
    i_i2c_eeprom_target (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(oe_a));
  i2c_eeprom_target #(.MEM_BYTES(512), .DEV_BASE(8'hB0), .DEV_MASK(8'h03), .HI_FROM_ADDR(1'b1))
    i_i2c_eeprom_target_paged (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(oe_b));
  i2c_eeprom_target #(.MEM_BYTES(64), .DEV_BASE(8'hC1), .DEV_MASK(8'h00), .HI_FROM_ADDR(1'b0))
    i_i2c_eeprom_target_ro (.clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(oe_c));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int r8_viol = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_val;
  event       rd_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs each byte read with the oldest expectation.
  always @(rd_ev) begin
    if (exp_q.size() == 0) begin
      chk(1'b0, "scoreboard underflow", int'(rd_val), 0);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_val == e, t, int'(rd_val), int'(e));
    end
  end

  // R8 watcher: no target may move its drive while SCL is high.
  logic oe_a_q, oe_b_q, oe_c_q, scl_q;
  always @(negedge clk) begin
    if (!rst && m_scl && scl_q &&
        (oe_a != oe_a_q || oe_b != oe_b_q || oe_c != oe_c_q))
      r8_viol++;
    oe_a_q = oe_a; oe_b_q = oe_b; oe_c_q = oe_c; scl_q = m_scl;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; m_scl = 1'b1; tick(H);
    m_low = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic i2c_rstart();
    m_low = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_low = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_low = 1'b0; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(H);
      m_scl = 1'b1;  tick(H/2);
      tick(H/2);
      m_scl = 1'b0;  tick(2);
    end
    m_low = 1'b0; tick(H);
    m_scl = 1'b1; tick(H/2);
    ack = ~sda_bus;
    tick(H/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic wr_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    logic a;
    wr_byte(b, a);
    chk(a == exp_ack, tag, int'(a), int'(exp_ack));
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] v);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      m_scl = 1'b1; tick(H/2);
      v[i] = sda_bus;
      tick(H/2);
      m_scl = 1'b0; tick(2);
    end
    m_low = give_ack; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(2);
    m_low = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] e, input bit give_ack, input string tag);
    logic [7:0] v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_byte(give_ack, v);
    rd_val = v;
    -> rd_ev;
    tick(1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog timeout (all requirements)", 1, 0);
      finish_run();
    end
  end

  initial begin
    tick(10);
    rst = 1'b0;
    tick(5);
    chk(sda_bus == 1'b1, "R1 SDA released during fill", int'(sda_bus), 1);
    tick(600);

    // R4 R6 R7: two offset bytes, three writes crossing the top of memory
    i2c_start();
    wr_chk(8'hA0, 1'b1, "R2 R6 address A0 ack");
    wr_chk(8'h01, 1'b1, "R4 R6 offset high ack");
    wr_chk(8'hFE, 1'b1, "R4 R6 offset low ack");
    wr_chk(8'h11, 1'b1, "R6 data ack 1");
    wr_chk(8'h22, 1'b1, "R6 data ack 2");
    wr_chk(8'h33, 1'b1, "R7 data ack after wrap");
    i2c_stop();

    // R7 R8: read back across the wrap; NACK ends the transfer
    i2c_start();
    wr_chk(8'hA0, 1'b1, "R2 address A0 ack");
    wr_chk(8'h01, 1'b1, "R4 offset high ack");
    wr_chk(8'hFE, 1'b1, "R4 offset low ack");
    i2c_rstart();
    wr_chk(8'hA1, 1'b1, "R10 repeated start read ack");
    rd_expect(8'h11, 1'b1, "R8 read byte at 0x1FE");
    rd_expect(8'h22, 1'b1, "R7 read byte at 0x1FF");
    rd_expect(8'h33, 1'b0, "R7 read byte wrapped to 0x000");
    rd_expect(8'hFF, 1'b0, "R8 released after NACK");
    i2c_stop();

    // R9: offset-only write, then a current-address read
    i2c_start();
    wr_chk(8'hA0, 1'b1, "R9 address ack");
    wr_chk(8'h01, 1'b1, "R9 offset high ack");
    wr_chk(8'hFF, 1'b1, "R9 offset low ack");
    i2c_stop();
    i2c_start();
    wr_chk(8'hA1, 1'b1, "R9 read address ack");
    rd_expect(8'h22, 1'b1, "R9 read starts at loaded offset");
    rd_expect(8'h33, 1'b0, "R7 R9 wrap on read");
    i2c_stop();

    // R1: untouched location of the 512-byte target reads erased
    i2c_start();
    wr_chk(8'hA0, 1'b1, "R1 address ack");
    wr_chk(8'h00, 1'b1, "R1 offset high ack");
    wr_chk(8'h40, 1'b1, "R1 offset low ack");
    i2c_rstart();
    wr_chk(8'hA1, 1'b1, "R1 read address ack");
    rd_expect(8'hFF, 1'b0, "R1 erased value");
    i2c_stop();

    // R2: non-matching address is refused and the rest is ignored
    i2c_start();
    wr_chk(8'hA4, 1'b0, "R2 mismatch NACK");
    wr_chk(8'h00, 1'b0, "R2 ignored until START");
    i2c_stop();

    // R10: after STOP, clocked bytes without START get no ACK
    m_scl = 1'b0; tick(2);
    wr_chk(8'hA0, 1'b0, "R10 no ACK after STOP");
    i2c_stop();

    // R5: paged target, address bit 1 selects the upper half
    i2c_start();
    wr_chk(8'hB2, 1'b1, "R5 paged write address ack");
    wr_chk(8'h10, 1'b1, "R5 single offset byte ack");
    wr_chk(8'h5A, 1'b1, "R5 data ack");
    i2c_stop();
    i2c_start();
    wr_chk(8'hB0, 1'b1, "R5 lower page address ack");
    wr_chk(8'h10, 1'b1, "R5 lower offset ack");
    i2c_rstart();
    wr_chk(8'hB1, 1'b1, "R5 lower read ack");
    rd_expect(8'hFF, 1'b0, "R5 lower half untouched");
    i2c_stop();
    i2c_start();
    wr_chk(8'hB2, 1'b1, "R5 upper page address ack");
    wr_chk(8'h10, 1'b1, "R5 upper offset ack");
    i2c_rstart();
    wr_chk(8'hB3, 1'b1, "R5 upper read ack");
    rd_expect(8'h5A, 1'b0, "R5 upper half holds data");
    i2c_stop();

    // R3: read-only target
    i2c_start();
    wr_chk(8'hC0, 1'b0, "R3 write direction refused");
    i2c_stop();
    i2c_start();
    wr_chk(8'hC1, 1'b1, "R3 read direction accepted");
    rd_expect(8'hFF, 1'b1, "R1 R3 erased byte 0");
    rd_expect(8'hFF, 1'b0, "R1 R3 erased byte 1");
    i2c_stop();

    tick(20);
    chk(r8_viol == 0, "R8 SDA moved while SCL high", r8_viol, 0);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule